// File: doc/BRIEF.md
# Transmit Low-Power-Idle Sequencer

This block decides when the transmit side of an Ethernet MAC may signal low-power idle toward the PHY, and how long the transmitter must stay quiet once that idle period ends. Software supplies an enable bit, an automatic-entry bit, a link-good bit and one packed timer word. The block also receives a millisecond strobe and a microsecond strobe from a shared timebase, plus a flag that tells it when the transmit queue holds data.

Entry into idle needs three things: both enable bits are set, the link bit has stayed high for a programmed number of milliseconds, and the transmit queue is empty. When new data arrives, or when software clears either enable bit, the idle indication drops at once. Transmit then stays held for a programmed number of microseconds. The block keeps four sticky event flags, covering idle entry and exit on the transmit path and on the receive path. The receive-path flags come from an idle indication reported by the PHY. An interrupt stays high while any flag is set, and a status-read strobe clears all four flags.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, tx_lpi, tx_hold, lpi_irq and all four bits of lpi_flags are 0.
- R2: The wake time sits in timer_word bits 15:0 and is counted in us_tick strobes. The link qualification time sits in timer_word bits 26:16 and is counted in ms_tick strobes.
- R3: tx_lpi rises on the clock edge after a cycle in which four things hold together: lpi_enable and auto_entry are both 1, tx_pending is 0, and link_up has been 1 for at least the programmed number of ms_tick strobes. It does not rise while fewer strobes have been counted.
- R4: The link qualification count returns to zero whenever link_up is 0, so every new link-good period must be timed again from the start. tx_lpi never rises while link_up is 0.
- R5: While tx_lpi is 1, tx_hold is also 1. When tx_pending is 1 during idle, tx_lpi falls on the next edge and tx_hold stays 1. tx_hold then falls on the edge after the one that takes in the wake-time-th us_tick strobe. With a wake time of 0, tx_hold stays high for exactly one cycle after idle ends.
- R6: Clearing lpi_enable or auto_entry during idle ends idle on the next edge and runs the same wake hold as R5. While either bit is 0, idle is not entered.
- R7: lpi_flags bit 0 sets when transmit idle is entered and bit 1 sets when it ends. Bit 2 sets on a rising edge of rx_lpi_in and bit 3 on a falling edge. Each bit stays set until it is cleared.
- R8: A status_rd strobe clears every flag on the next edge, except a flag whose event happens in that same cycle, which stays set. lpi_irq is 1 exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpi_enable | input | 1 | Idle feature enable |
| auto_entry | input | 1 | Allow automatic transmit idle entry |
| link_up | input | 1 | Software-written link-good bit |
| timer_word | input | 32 | Packed wake time [15:0] and link time [26:16] |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| us_tick | input | 1 | One-cycle microsecond strobe |
| tx_pending | input | 1 | Transmit queue holds data |
| rx_lpi_in | input | 1 | Receive-path idle indication from the PHY |
| status_rd | input | 1 | Status read strobe, clears flags |
| tx_lpi | output | 1 | Request idle signalling toward the PHY |
| tx_hold | output | 1 | Transmit must not start |
| lpi_flags | output | 4 | Sticky event flags: tx enter, tx exit, rx enter, rx exit |
| lpi_irq | output | 1 | Any flag set |

## Verification
The bench keeps the default field widths: an 11-bit link time and a 16-bit wake time. It programs small values into the timer word, such as a link time of 3 and a wake time of 2, and also zero. Because the bench drives the tick strobes by hand, these values make it possible to reach the exact edge on which qualification completes, a link drop in the middle of qualification, and the one-cycle wake hold that a zero wake time gives. The same setup also reaches a read strobe that lands in the same cycle as a new receive event.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    localparam int FLAG_CNT     = 4;
    localparam int FLG_TX_ENTER = 0;
    localparam int FLG_TX_EXIT  = 1;
    localparam int FLG_RX_ENTER = 2;
    localparam int FLG_RX_EXIT  = 3;

endpackage

// File: rtl/lpi_link_qual.sv
module lpi_link_qual #(
    parameter int LS_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_ok,
    input  logic            ms_tick,
    input  logic [LS_W-1:0] ls_limit,
    output logic            link_good
);
    localparam logic [LS_W-1:0] CNT_MAX = {LS_W{1'b1}};

    typedef struct packed {
        logic [LS_W-1:0] cnt;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!link_ok) begin
            st_d.cnt = '0;
        end else if (ms_tick && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign link_good = link_ok && (st_q.cnt >= ls_limit);

    p_restart_on_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> st_q.cnt == '0);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok && ms_tick && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

endmodule

// File: rtl/lpi_wake_timer.sv
module lpi_wake_timer #(
    parameter int TW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TW_W-1:0] load_val,
    input  logic            us_tick,
    output logic            expired
);
    typedef struct packed {
        logic [TW_W-1:0] cnt;
    } wake_t;

    wake_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (us_tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == '0);

    p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && us_tick && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.cnt == $past(load_val));

endmodule

// File: rtl/lpi_event_flags.sv
module lpi_event_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         clr,
    output logic [N-1:0] flags,
    output logic         any_set
);
    typedef struct packed {
        logic [N-1:0] bits;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_ev[i]) begin
                st_d.bits[i] = 1'b1;
            end else if (clr) begin
                st_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags   = st_q.bits;
    assign any_set = |st_q.bits;

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_ev == '0) |=> flags == '0);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (flags & $past(flags)) == $past(flags));

    p_event_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> (flags & $past(set_ev)) == $past(set_ev));

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl #(
    parameter int LS_W   = 11,
    parameter int TW_W   = 16,
    parameter int WORD_W = 32,
    parameter int LS_LSB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lpi_enable,
    input  logic        auto_entry,
    input  logic        link_up,
    input  logic [31:0] timer_word,
    input  logic        ms_tick,
    input  logic        us_tick,
    input  logic        tx_pending,
    input  logic        rx_lpi_in,
    input  logic        status_rd,
    output logic        tx_lpi,
    output logic        tx_hold,
    output logic [3:0]  lpi_flags,
    output logic        lpi_irq
);
    import lpi_pkg::*;

    localparam int LS_MSB = LS_LSB + LS_W - 1;
    localparam int TW_MSB = TW_W - 1;

    typedef struct packed {
        lpi_state_e state;
        logic       rx_prev;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [LS_W-1:0]     ls_val;
    logic [TW_W-1:0]     tw_val;
    logic                link_good;
    logic                wake_done;
    logic                wake_load;
    logic                allow;
    logic [FLAG_CNT-1:0] ev;
    logic [WORD_W-1:0]   word_ext;

    assign word_ext = WORD_W'(timer_word);
    assign ls_val   = word_ext[LS_MSB:LS_LSB];
    assign tw_val   = word_ext[TW_MSB:0];
    assign allow    = lpi_enable && auto_entry;

    lpi_link_qual #(.LS_W(LS_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_ok   (link_up),
        .ms_tick   (ms_tick),
        .ls_limit  (ls_val),
        .link_good (link_good)
    );

    lpi_wake_timer #(.TW_W(TW_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .load_val (tw_val),
        .us_tick  (us_tick),
        .expired  (wake_done)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rx_prev = rx_lpi_in;
        wake_load    = 1'b0;
        unique case (st_q.state)
            ST_ACTIVE: begin
                if (allow && link_good && !tx_pending) begin
                    st_d.state = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (tx_pending || !allow) begin
                    st_d.state = ST_WAKE;
                    wake_load  = 1'b1;
                end
            end
            ST_WAKE: begin
                if (wake_done) begin
                    st_d.state = ST_ACTIVE;
                end
            end
            default: st_d.state = ST_ACTIVE;
        endcase

        ev               = '0;
        ev[FLG_TX_ENTER] = (st_q.state == ST_ACTIVE) && (st_d.state == ST_SLEEP);
        ev[FLG_TX_EXIT]  = wake_load;
        ev[FLG_RX_ENTER] = rx_lpi_in && !st_q.rx_prev;
        ev[FLG_RX_EXIT]  = !rx_lpi_in && st_q.rx_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_ACTIVE, rx_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    lpi_event_flags #(.N(FLAG_CNT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (ev),
        .clr     (status_rd),
        .flags   (lpi_flags),
        .any_set (lpi_irq)
    );

    assign tx_lpi  = (st_q.state == ST_SLEEP);
    assign tx_hold = (st_q.state != ST_ACTIVE);

    p_entry_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi) |-> $past(link_good && allow && !tx_pending));

    p_no_entry_link_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_lpi && !link_up) |=> !tx_lpi);

    p_data_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi && tx_pending) |=> (!tx_lpi && tx_hold));

    p_disable_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi && !allow) |=> (!tx_lpi && tx_hold));

    p_hold_covers_lpi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lpi |-> tx_hold);

    p_irq_tracks_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi) |-> lpi_irq);

endmodule

// File: tb/eee_lpi_ctrl_tb_top.sv
module eee_lpi_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lpi_enable = 1'b0;
    logic        auto_entry = 1'b0;
    logic        link_up = 1'b0;
    logic [31:0] timer_word = '0;
    logic        ms_tick = 1'b0;
    logic        us_tick = 1'b0;
    logic        tx_pending = 1'b1;
    logic        rx_lpi_in = 1'b0;
    logic        status_rd = 1'b0;
    logic        tx_lpi;
    logic        tx_hold;
    logic [3:0]  lpi_flags;
    logic        lpi_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eee_lpi_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lpi_enable (lpi_enable),
        .auto_entry (auto_entry),
        .link_up    (link_up),
        .timer_word (timer_word),
        .ms_tick    (ms_tick),
        .us_tick    (us_tick),
        .tx_pending (tx_pending),
        .rx_lpi_in  (rx_lpi_in),
        .status_rd  (status_rd),
        .tx_lpi     (tx_lpi),
        .tx_hold    (tx_hold),
        .lpi_flags  (lpi_flags),
        .lpi_irq    (lpi_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ms();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic pulse_us();
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic read_status();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    function automatic logic [31:0] tword(int ls, int tw);
        return (32'(ls) << 16) | 32'(tw);
    endfunction

    task automatic t_reset();
        check("R1 tx_lpi", 32'(tx_lpi), 0);
        check("R1 tx_hold", 32'(tx_hold), 0);
        check("R1 flags", 32'(lpi_flags), 0);
        check("R1 irq", 32'(lpi_irq), 0);
    endtask

    task automatic t_entry();
        timer_word = tword(3, 2);
        lpi_enable = 1'b1;
        auto_entry = 1'b1;
        link_up    = 1'b1;
        tx_pending = 1'b0;
        cycles(2);
        pulse_ms();
        pulse_ms();
        cycles(3);
        check("R3 no entry before LS ms", 32'(tx_lpi), 0);
        pulse_ms();
        check("R2 LS field bits 26:16 honoured", 32'(tx_lpi), 0);
        cycles(1);
        check("R3 entry after LS ms", 32'(tx_lpi), 1);
        check("R5 hold during idle", 32'(tx_hold), 1);
        check("R7 tx enter flag", 32'(lpi_flags), 4'b0001);
        check("R8 irq with flag", 32'(lpi_irq), 1);
    endtask

    task automatic t_read_clear();
        read_status();
        check("R8 read clears flags", 32'(lpi_flags), 0);
        check("R8 irq drops", 32'(lpi_irq), 0);
        check("R3 idle persists", 32'(tx_lpi), 1);
    endtask

    task automatic t_data_wake();
        tx_pending = 1'b1;
        cycles(1);
        check("R5 lpi drops on data", 32'(tx_lpi), 0);
        check("R5 hold on data", 32'(tx_hold), 1);
        check("R7 tx exit flag", 32'(lpi_flags), 4'b0010);
        pulse_us();
        cycles(2);
        check("R5 hold before TW", 32'(tx_hold), 1);
        pulse_us();
        check("R2 TW field bits 15:0 honoured", 32'(tx_hold), 1);
        cycles(1);
        check("R5 hold released after TW", 32'(tx_hold), 0);
        check("R5 no reentry with data", 32'(tx_lpi), 0);
    endtask

    task automatic t_link_restart();
        link_up = 1'b0;
        cycles(1);
        link_up = 1'b1;
        pulse_ms();
        pulse_ms();
        link_up = 1'b0;
        tx_pending = 1'b0;
        cycles(3);
        check("R4 no entry while link down", 32'(tx_lpi), 0);
        link_up = 1'b1;
        pulse_ms();
        pulse_ms();
        cycles(3);
        check("R4 count restarted after drop", 32'(tx_lpi), 0);
        pulse_ms();
        cycles(1);
        check("R4 entry after fresh LS", 32'(tx_lpi), 1);
    endtask

    task automatic t_enable_clear();
        read_status();
        auto_entry = 1'b0;
        cycles(1);
        check("R6 auto clear exits", 32'(tx_lpi), 0);
        check("R6 hold after exit", 32'(tx_hold), 1);
        pulse_us();
        pulse_us();
        cycles(1);
        check("R6 wake hold ends", 32'(tx_hold), 0);
        auto_entry = 1'b1;
        lpi_enable = 1'b0;
        cycles(4);
        check("R6 no entry while disabled", 32'(tx_lpi), 0);
        lpi_enable = 1'b1;
        cycles(1);
        check("R6 entry once enabled", 32'(tx_lpi), 1);
        lpi_enable = 1'b0;
        cycles(1);
        check("R6 enable clear exits", 32'(tx_lpi), 0);
        lpi_enable = 1'b1;
        tx_pending = 1'b1;
        pulse_us();
        pulse_us();
        cycles(1);
        check("R6 wake after enable clear", 32'(tx_hold), 0);
    endtask

    task automatic t_tw_zero();
        timer_word = tword(0, 0);
        tx_pending = 1'b0;
        cycles(1);
        check("R3 ls zero enters at once", 32'(tx_lpi), 1);
        tx_pending = 1'b1;
        cycles(1);
        check("R5 tw zero hold one cycle", 32'(tx_hold), 1);
        cycles(1);
        check("R5 tw zero hold released", 32'(tx_hold), 0);
    endtask

    task automatic t_rx_flags();
        read_status();
        check("R8 cleared before rx", 32'(lpi_flags), 0);
        rx_lpi_in = 1'b1;
        cycles(1);
        check("R7 rx enter flag", 32'(lpi_flags), 4'b0100);
        rx_lpi_in = 1'b0;
        cycles(1);
        check("R7 rx exit flag", 32'(lpi_flags), 4'b1100);
        rx_lpi_in = 1'b1;
        status_rd = 1'b1;
        cycles(1);
        status_rd = 1'b0;
        check("R8 event during read kept", 32'(lpi_flags), 4'b0100);
        check("R8 irq still set", 32'(lpi_irq), 1);
    endtask

    initial begin
        cycles(3);
        t_reset();
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_entry();
        t_read_clear();
        t_data_wake();
        t_link_restart();
        t_enable_clear();
        t_tw_zero();
        t_rx_flags();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule